// File: doc/BRIEF.md
# Banked Nibble Data Memory

This block is the data store of a small 4-bit controller core. A request carries a 4-bit bank number and an 8-bit offset. Banks 0 and 1 are held inside the block as 256 nibbles each. Bank 15 is not stored here: a request to it is passed on, in the same cycle, to an external memory-mapped I/O port. Any other bank number is rejected. In bank 0, offsets 00h to 1Fh belong to the core's working registers. The upper part of bank 0 holds the stack and general data.

A request moves either one nibble or one byte. A byte is a pair of nibbles. The even offset holds the low nibble and the next offset holds the high nibble. A byte request at an odd offset is refused.

The block also keeps the 8-bit stack pointer. A push first decrements the pointer and then writes one nibble into bank 0. A pop reads bank 0 at the pointer and then increments it. Read results appear one clock after the request, and writes take effect on the request's clock edge.

Top module: `nibble_bank_mem`

## Requirements
- R1: After reset, `rd_valid` and `err` are 0 and `sp` is 00h.
- R2: A nibble read of bank 0 or bank 1 returns, one cycle later, `rd_valid`=1 and `rd_data` = {4'h0, stored nibble}. A nibble write stores `req_wdata[3:0]` at the offset.
- R3: Bank 0 (bank code 0) and bank 1 (bank code 1) are separate storage. A write to an offset in one bank leaves the same offset in the other bank unchanged.
- R4: A byte access (`req_byte`=1) at even offset a uses offset a for bits [3:0] and offset a+1 for bits [7:4]. A byte read returns {nibble[a+1], nibble[a]}.
- R5: A byte access at an odd offset sets `err` for one cycle, one cycle after the request. It writes nothing, gives no `rd_valid`, and does not raise `io_req`.
- R6: An access to any bank code other than 0, 1 and 15 sets `err` one cycle later. It writes nothing, gives no `rd_valid`, and does not raise `io_req`.
- R7: A valid access to bank code 15 raises `io_req` in the same cycle and forwards the offset, direction, width and write data to the port. Internal storage is not touched. A read returns `io_rdata` as sampled in the request cycle, one cycle later, with bits [7:4] forced to 0 for a nibble read.
- R8: A push (push=1, pop=0) decrements `sp` and writes `push_data` into bank 0 at the new `sp`.
- R9: A pop (pop=1, push=0) returns {4'h0, bank0[sp]} with `rd_valid` one cycle later and increments `sp`.
- R10: Push and pop asserted in the same cycle set `err` one cycle later. `sp` and memory stay unchanged.
- R11: While push or pop is high, `req_valid` is ignored. The request causes no write, no `io_req` and no result of its own.
- R12: `sp` wraps modulo 256, so a push from 00h stores at FFh and a pop from FFh leaves 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte (nibble pair), 0 = nibble |
| req_bank | input | 4 | Bank code |
| req_addr | input | 8 | Nibble offset within the bank |
| req_wdata | input | 8 | Write data; only [3:0] is used for a nibble write |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| push_data | input | 4 | Nibble to push |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Read result |
| err | output | 1 | Rejected request, one-cycle pulse |
| sp | output | 8 | Stack pointer |
| io_req | output | 1 | I/O port access |
| io_write | output | 1 | I/O write direction |
| io_byte | output | 1 | I/O access width |
| io_addr | output | 8 | I/O offset |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data |

## Verification
The hardest cases to reach from the ports are a request that arrives in the same cycle as a stack operation, and a push that collides with a pop. In both cases the damage would be silent: a stray write, or a pointer that shifts. The bench therefore drives a bank write together with a push, and a read together with a pop. It then reads the targeted offset back and checks that exactly one result came out. For a clash, it reads back the slot a push would have filled. Odd-offset byte requests are also aimed at bank 15, so the misalignment check has to win over the I/O forwarding.

// File: rtl/nibble_bank_mem.sv
module nibble_bank_mem #(
  parameter int AW      = 8,
  parameter int NW      = 4,
  parameter int BW      = 4,
  parameter int IO_BANK = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_byte,
  input  logic [BW-1:0]   req_bank,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*NW-1:0] req_wdata,
  input  logic            push,
  input  logic            pop,
  input  logic [NW-1:0]   push_data,
  output logic            rd_valid,
  output logic [2*NW-1:0] rd_data,
  output logic            err,
  output logic [AW-1:0]   sp,
  output logic            io_req,
  output logic            io_write,
  output logic            io_byte,
  output logic [AW-1:0]   io_addr,
  output logic [2*NW-1:0] io_wdata,
  input  logic [2*NW-1:0] io_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [NW-1:0] bank0 [DEPTH];
  logic [NW-1:0] bank1 [DEPTH];

  wire do_push  = push & ~pop;
  wire do_pop   = pop & ~push;
  wire clash    = push & pop;
  wire acc      = req_valid & ~push & ~pop;
  wire bank_ok  = (req_bank == BW'(0)) | (req_bank == BW'(1)) | (req_bank == BW'(IO_BANK));
  wire acc_bad  = acc & (~bank_ok | (req_byte & req_addr[0]));
  wire acc_ok   = acc & ~acc_bad;
  wire hit_io   = acc_ok & (req_bank == BW'(IO_BANK));
  wire hit_b0   = acc_ok & (req_bank == BW'(0));
  wire hit_b1   = acc_ok & (req_bank == BW'(1));

  wire [AW-1:0] sp_dn   = sp - 1'b1;
  wire [AW-1:0] addr_hi = req_addr | AW'(1);

  assign io_req   = hit_io;
  assign io_write = req_write;
  assign io_byte  = req_byte;
  assign io_addr  = req_addr;
  assign io_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (do_push) bank0[sp_dn] <= push_data;
    if (hit_b0 && req_write) begin
      bank0[req_addr] <= req_wdata[NW-1:0];
      if (req_byte) bank0[addr_hi] <= req_wdata[2*NW-1:NW];
    end
    if (hit_b1 && req_write) begin
      bank1[req_addr] <= req_wdata[NW-1:0];
      if (req_byte) bank1[addr_hi] <= req_wdata[2*NW-1:NW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp       <= '0;
      rd_valid <= 1'b0;
      err      <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_pop | (acc_ok & ~req_write);
      err      <= clash | acc_bad;
      if (do_push)     sp <= sp_dn;
      else if (do_pop) sp <= sp + 1'b1;
      if (do_pop)
        rd_data <= {{NW{1'b0}}, bank0[sp]};
      else if (hit_io)
        rd_data <= req_byte ? io_rdata : {{NW{1'b0}}, io_rdata[NW-1:0]};
      else if (hit_b0)
        rd_data <= req_byte ? {bank0[addr_hi], bank0[req_addr]} : {{NW{1'b0}}, bank0[req_addr]};
      else if (hit_b1)
        rd_data <= req_byte ? {bank1[addr_hi], bank1[req_addr]} : {{NW{1'b0}}, bank1[req_addr]};
    end
  end

  p_push_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (sp == AW'($past(sp) - 1'b1)));
  p_pop_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (sp == AW'($past(sp) + 1'b1)));
  p_clash_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> ($stable(sp) && err && !rd_valid));
  p_io_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> (!push && !pop));
  p_err_no_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_valid);
  p_rdv_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid || pop));
endmodule

// File: tb/nibble_bank_mem_bench.sv
module nibble_bank_mem_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_byte = 0;
  logic [3:0] req_bank = 0;
  logic [7:0] req_addr = 0, req_wdata = 0, io_rdata = 0;
  logic push = 0, pop = 0;
  logic [3:0] push_data = 0;
  logic rd_valid, err, io_req, io_write, io_byte;
  logic [7:0] rd_data, sp, io_addr, io_wdata;

  nibble_bank_mem u_nibble_bank_mem (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [3:0] m0 [256];
  logic [3:0] m1 [256];
  logic [7:0] msp = 0;
  logic [7:0] q_d [$];
  bit         q_e [$];
  string      q_t [$];

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && (rd_valid || err)) begin
    if (q_d.size() == 0) chk(0, "unexpected result", {6'b0, rd_valid, err}, 8'h00);
    else begin
      logic [7:0] d; bit e; string t;
      d = q_d.pop_front(); e = q_e.pop_front(); t = q_t.pop_front();
      if (e) chk(err && !rd_valid, t, {6'b0, rd_valid, err}, 8'h01);
      else   chk(rd_valid && !err && rd_data == d, t, rd_data, d);
    end
  end

  task automatic expect_item(input logic [7:0] d, input bit e, input string t);
    q_d.push_back(d); q_e.push_back(e); q_t.push_back(t);
  endtask

  task automatic acc(input bit w, input bit b, input logic [3:0] bk, input logic [7:0] a,
                     input logic [7:0] wd, input string tag);
    bit bad;
    logic [7:0] a1;
    bad = !(bk == 0 || bk == 1 || bk == 15) || (b && a[0]);
    a1 = a | 8'h01;
    @(negedge clk);
    req_valid = 1; req_write = w; req_byte = b; req_bank = bk; req_addr = a; req_wdata = wd;
    if (bad) expect_item(8'h00, 1, tag);
    else if (!w) begin
      if (bk == 15)     expect_item(b ? io_rdata : {4'h0, io_rdata[3:0]}, 0, tag);
      else if (bk == 0) expect_item(b ? {m0[a1], m0[a]} : {4'h0, m0[a]}, 0, tag);
      else              expect_item(b ? {m1[a1], m1[a]} : {4'h0, m1[a]}, 0, tag);
    end else if (bk == 0) begin m0[a] = wd[3:0]; if (b) m0[a1] = wd[7:4]; end
    else if (bk == 1)     begin m1[a] = wd[3:0]; if (b) m1[a1] = wd[7:4]; end
    #1;
    if (bk == 15 && !bad)
      chk(io_req && io_write == w && io_byte == b && io_addr == a && io_wdata == wd,
          {tag, " io fwd R7"}, io_addr, a);
    else chk(!io_req, {tag, " no io"}, {7'b0, io_req}, 8'h00);
    @(negedge clk);
    req_valid = 0; req_write = 0; req_byte = 0;
  endtask

  task automatic stk(input bit pu, input bit po, input logic [3:0] nib, input bit with_req,
                     input string tag);
    @(negedge clk);
    push = pu; pop = po; push_data = nib;
    if (with_req) begin
      req_valid = 1; req_write = 1; req_bank = 1; req_addr = 8'h20; req_wdata = 8'h00;
    end
    if (pu && po) expect_item(8'h00, 1, tag);
    else if (pu) begin msp = msp - 1; m0[msp] = nib; end
    else begin expect_item({4'h0, m0[msp]}, 0, tag); msp = msp + 1; end
    #1 chk(!io_req, {tag, " no io R11"}, {7'b0, io_req}, 8'h00);
    @(negedge clk);
    push = 0; pop = 0; req_valid = 0; req_write = 0;
    chk(sp == msp, {tag, " sp"}, sp, msp);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    chk(0, "watchdog", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_valid && !err && sp == 8'h00, "R1 reset state", sp, 8'h00);

    acc(1, 0, 0, 8'h20, 8'h05, "R2 write b0");
    acc(1, 0, 1, 8'h20, 8'h0A, "R3 write b1");
    acc(0, 0, 0, 8'h20, 8'h00, "R3 read b0 after b1 write");
    acc(0, 0, 1, 8'h20, 8'h00, "R2 read b1");
    acc(1, 0, 0, 8'h21, 8'hF6, "R2 write uses low nibble");
    acc(0, 0, 0, 8'h21, 8'h00, "R2 read nibble 6");

    acc(1, 1, 1, 8'h40, 8'h3C, "R4 byte write");
    acc(0, 1, 1, 8'h40, 8'h00, "R4 byte read");
    acc(0, 0, 1, 8'h41, 8'h00, "R4 high nibble at odd offset");
    acc(0, 0, 1, 8'h40, 8'h00, "R4 low nibble at even offset");
    acc(1, 0, 0, 8'h50, 8'h01, "R4 nib 50");
    acc(1, 0, 0, 8'h51, 8'h09, "R4 nib 51");
    acc(0, 1, 0, 8'h50, 8'h00, "R4 byte from nibbles");

    acc(1, 1, 1, 8'h41, 8'hFF, "R5 odd byte write");
    acc(0, 1, 1, 8'h40, 8'h00, "R5 pair unchanged");
    acc(0, 1, 0, 8'h51, 8'h00, "R5 odd byte read");
    acc(1, 1, 15, 8'h11, 8'h77, "R5 odd byte to io bank");

    acc(1, 0, 2, 8'h20, 8'h07, "R6 write bank 2");
    acc(0, 0, 7, 8'h20, 8'h00, "R6 read bank 7");
    acc(1, 0, 14, 8'h20, 8'h03, "R6 write bank 14");
    acc(0, 0, 0, 8'h20, 8'h00, "R6 b0 unchanged");
    acc(0, 0, 1, 8'h20, 8'h00, "R6 b1 unchanged");

    io_rdata = 8'h6B;
    acc(0, 1, 15, 8'h10, 8'h00, "R7 io byte read");
    acc(0, 0, 15, 8'h33, 8'h00, "R7 io nibble read");
    acc(1, 0, 15, 8'h20, 8'h0E, "R7 io write");
    acc(1, 1, 15, 8'h20, 8'hD2, "R7 io byte write");
    acc(0, 1, 0, 8'h20, 8'h00, "R7 b0 untouched");
    acc(0, 0, 1, 8'h20, 8'h00, "R7 b1 untouched");

    stk(1, 0, 4'h4, 0, "R12 push from 00 wraps");
    chk(sp == 8'hFF, "R12 sp at FF", sp, 8'hFF);
    acc(0, 0, 0, 8'hFF, 8'h00, "R8 pushed nibble at FF");
    stk(1, 0, 4'h7, 0, "R8 second push");
    acc(0, 0, 0, 8'hFE, 8'h00, "R8 pushed nibble at FE");
    stk(0, 1, 4'h0, 0, "R9 pop 7");
    stk(0, 1, 4'h0, 0, "R9 R12 pop wraps to 00");

    stk(1, 1, 4'h2, 0, "R10 push pop clash");
    acc(0, 0, 0, 8'hFF, 8'h00, "R10 FF unchanged");

    stk(1, 0, 4'h9, 1, "R11 push with request");
    acc(0, 0, 1, 8'h20, 8'h00, "R11 b1 not written");
    @(negedge clk);
    pop = 1; req_valid = 1; req_write = 0; req_bank = 0; req_addr = 8'h21;
    expect_item({4'h0, m0[msp]}, 0, "R11 pop with read gives one result");
    msp = msp + 1;
    #1 chk(!io_req, "R11 no io on pop", {7'b0, io_req}, 8'h00);
    @(negedge clk);
    pop = 0; req_valid = 0;
    chk(sp == msp, "R9 sp after pop", sp, msp);

    repeat (3) @(negedge clk);
    chk(q_d.size() == 0, "all expected results seen", 8'(q_d.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule